// File: doc/BRIEF.md
# Active-Clamp Complementary PWM Sequencer

This block produces the two gate-drive timing signals of an active-clamp forward converter. One is the main switch and the other is the auxiliary clamp switch. Each switching period is counted in system clocks and split into four slots:

1. a dead slot,
2. the main on-time,
3. a second dead slot,
4. the clamp on-time, which runs to the end of the period.

The clamp signal is therefore the complement of the main signal, with a programmable dead slot on each side. The period, the duty command and both dead slots are taken only when a period begins, so a pulse is never cut or stretched in mid-cycle by a new setting.

Protection is by latch only; there is no per-cycle current limit. An overcurrent or line-dropout input sets a fault latch, which takes the main drive low at once. Releasing the latch takes a restart strobe, given only once the fault inputs are quiet and the line is good. After release, a soft-start limit climbs from zero. When the effective on-time is too short to be useful, both switches stay off for the whole period instead of emitting a sliver pair. While the line-good input is low, the main drive stays off and the clamp keeps pulsing at its widest permitted width, so that the clamp capacitor drains.

Top module: `clamp_pwm_seq`

## Requirements
- R1: While `rst_n` is low, and for two clock edges after it rises, both outputs are low, the fault latch is clear and the soft-start limit is zero.
- R2: `main_o` and `aux_o` are never high in the same cycle. At least one low cycle separates the fall of either output from the rise of the other.
- R3: A period lasts `period_i` clocks, with counter values 0 to P-1; a zero period behaves as one clock. `main_o` is high for counter values in [D1, D1+ON). `aux_o` is high for counter values in [D1+ON+D2, P). Each output is registered one clock after its counter value.
- R4: The two dead slots are programmed separately: `dly1_i` sets clamp-off to main-on (D1) and `dly2_i` sets main-off to clamp-on (D2). A dead value of 0 is treated as 1.
- R5: The period, duty and dead inputs are sampled only at the last clock of a period. Changes at other times leave the running period unchanged.
- R6: ON is the smallest of three values: `duty_i`, the soft-start limit, and P-D1-D2 (which is 0 when D1+D2 >= P).
- R7: If ON is below `MIN_ON` in a period that is neither faulted nor line-low, both outputs stay low for that whole period.
- R8: A period that begins with `line_ok_i` low has `main_o` low throughout. In that period `aux_o` is high from D1+D2 to the end of the period.
- R9: A high `oc_flt_i` or `uv_flt_i` sets the fault latch (`fault_o`) on the next edge, and `main_o` is low from the cycle after. Later periods keep both outputs low unless the line is low. The latch clears only on a `restart_i` pulse seen while both fault inputs are low and `line_ok_i` is high. Setting the latch takes priority over clearing it.
- R10: The soft-start limit is held at zero while the latch is set or the line is low. Otherwise it rises by `SS_STEP` once every `SS_DIV` period ends, saturating at full scale, and stops rising once it is no less than `duty_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| period_i | input | CNT_W | Switching period in clocks |
| duty_i | input | CNT_W | Commanded main on-time in clocks |
| dly1_i | input | CNT_W | Dead slot before main turn-on |
| dly2_i | input | CNT_W | Dead slot before clamp turn-on |
| line_ok_i | input | 1 | Line-good level |
| uv_flt_i | input | 1 | Line-dropout fault |
| oc_flt_i | input | 1 | Overcurrent fault |
| restart_i | input | 1 | Strobe that releases the fault latch |
| main_o | output | 1 | Main switch drive |
| aux_o | output | 1 | Clamp switch drive |
| fault_o | output | 1 | Fault latch state |

## Verification
The hardest case to reach from the ports is a fault that arrives while the main pulse is high, followed by a restart strobe given while a fault input is still asserted. The stimulus lets the soft-start ramp reach a steady pulse first. It then raises the overcurrent input for a single cycle part-way into a period and strobes restart with the input held high, which must leave the latch set. Finally it clears the input and strobes again. The clamp-drain case is reached by dropping the line with a duty command well above the period room, so that only the clamp width shows the P-D1-D2 rule.

// File: rtl/clamp_pwm_pkg.sv
package clamp_pwm_pkg;

  typedef enum logic [1:0] {
    FR_BLANK = 2'd0,
    FR_RUN   = 2'd1,
    FR_DRAIN = 2'd2
  } frame_mode_e;

endpackage

// File: rtl/cpw_rst_sync.sv
module cpw_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];

endmodule

// File: rtl/cpw_softstart.sv
module cpw_softstart #(
  parameter int CNT_W   = 10,
  parameter int SS_DIV  = 16,
  parameter int SS_STEP = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_ok_i,
  input  logic             uv_flt_i,
  input  logic             oc_flt_i,
  input  logic             restart_i,
  input  logic [CNT_W-1:0] duty_i,
  input  logic             frame_end_i,
  output logic             fault_o,
  output logic [CNT_W-1:0] limit_o
);

  localparam int DIV_W = (SS_DIV > 1) ? $clog2(SS_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SS_DIV - 1);
  localparam logic [CNT_W:0]   STEP_X   = (CNT_W+1)'(SS_STEP);

  logic             flt_q, flt_n;
  logic [CNT_W-1:0] lim_q, lim_n;
  logic [DIV_W-1:0] pcnt_q, pcnt_n;
  logic [CNT_W:0]   lim_sum;
  logic             trip, hold;

  assign trip    = uv_flt_i | oc_flt_i;
  assign hold    = flt_q | ~line_ok_i;
  assign lim_sum = {1'b0, lim_q} + STEP_X;

  always_comb begin
    flt_n = flt_q;
    if (trip)
      flt_n = 1'b1;
    else if (flt_q && line_ok_i && restart_i)
      flt_n = 1'b0;
  end

  always_comb begin
    lim_n  = lim_q;
    pcnt_n = pcnt_q;
    if (hold) begin
      lim_n  = '0;
      pcnt_n = '0;
    end else if (frame_end_i) begin
      if (pcnt_q >= DIV_LAST) begin
        pcnt_n = '0;
        if (lim_q < duty_i)
          lim_n = lim_sum[CNT_W] ? {CNT_W{1'b1}} : lim_sum[CNT_W-1:0];
      end else begin
        pcnt_n = pcnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flt_q  <= 1'b0;
      lim_q  <= '0;
      pcnt_q <= '0;
    end else begin
      flt_q  <= flt_n;
      lim_q  <= lim_n;
      pcnt_q <= pcnt_n;
    end
  end

  assign fault_o = flt_q;
  assign limit_o = lim_q;

  a_r9_fault_sets: assert property (@(posedge clk) disable iff (!rst_n)
    trip |=> fault_o);

  a_r9_fault_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_o && !restart_i) |=> fault_o);

  a_r10_limit_held: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_o || !line_ok_i) |=> (limit_o == '0));

  a_r10_limit_steps_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_end_i && line_ok_i && !fault_o) |=> $stable(limit_o));

endmodule

// File: rtl/cpw_frame.sv
module cpw_frame
  import clamp_pwm_pkg::*;
#(
  parameter int CNT_W  = 10,
  parameter int MIN_ON = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] duty_i,
  input  logic [CNT_W-1:0] dly1_i,
  input  logic [CNT_W-1:0] dly2_i,
  input  logic             line_ok_i,
  input  logic             fault_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             frame_end_o,
  output logic             main_o,
  output logic             aux_o
);

  localparam int SW = CNT_W + 2;
  localparam logic [SW-1:0] ONE_X    = SW'(1);
  localparam logic [SW-1:0] MIN_ON_X = SW'(MIN_ON);

  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [SW-1:0]    per_q, per_n;
  logic [SW-1:0]    mb_q, mb_n, me_q, me_n, ab_q, ab_n;
  frame_mode_e      mode_q, mode_n;
  logic             main_q, main_n, aux_q, aux_n;

  logic [SW-1:0] d1e, d2e, gap, per_x, room, cmd, on_c, cnt_x;
  logic          last;

  assign cnt_x = SW'(cnt_q);
  assign last  = (cnt_x + ONE_X) >= per_q;

  // load-time arithmetic for the next period
  always_comb begin
    d1e   = (dly1_i == '0) ? ONE_X : SW'(dly1_i);
    d2e   = (dly2_i == '0) ? ONE_X : SW'(dly2_i);
    gap   = d1e + d2e;
    per_x = SW'(period_i);
    room  = (gap >= per_x) ? '0 : (per_x - gap);
    cmd   = (duty_i < limit_i) ? SW'(duty_i) : SW'(limit_i);
    on_c  = (cmd < room) ? cmd : room;
  end

  // frame counter and snapshot next state
  always_comb begin
    cnt_n  = cnt_q;
    per_n  = per_q;
    mb_n   = mb_q;
    me_n   = me_q;
    ab_n   = ab_q;
    mode_n = mode_q;
    if (last) begin
      cnt_n = '0;
      per_n = per_x;
      if (!line_ok_i) begin
        mode_n = FR_DRAIN;
        mb_n   = d1e;
        me_n   = d1e;
        ab_n   = gap;
      end else if (fault_i || (on_c < MIN_ON_X)) begin
        mode_n = FR_BLANK;
        mb_n   = d1e;
        me_n   = d1e;
        ab_n   = gap;
      end else begin
        mode_n = FR_RUN;
        mb_n   = d1e;
        me_n   = d1e + on_c;
        ab_n   = gap + on_c;
      end
    end else begin
      cnt_n = cnt_q + 1'b1;
    end
  end

  // slot decode, registered to the pins
  always_comb begin
    main_n = (mode_q == FR_RUN) && !fault_i && (cnt_x >= mb_q) && (cnt_x < me_q);
    aux_n  = (mode_q != FR_BLANK) && (cnt_x >= ab_q) && (cnt_x < per_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      per_q  <= '0;
      mb_q   <= '0;
      me_q   <= '0;
      ab_q   <= '0;
      mode_q <= FR_BLANK;
      main_q <= 1'b0;
      aux_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      per_q  <= per_n;
      mb_q   <= mb_n;
      me_q   <= me_n;
      ab_q   <= ab_n;
      mode_q <= mode_n;
      main_q <= main_n;
      aux_q  <= aux_n;
    end
  end

  assign frame_end_o = last;
  assign main_o      = main_q;
  assign aux_o       = aux_q;

  a_r2_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(main_o && aux_o));

  a_r2_gap_before_main: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(main_o) |-> !$past(aux_o));

  a_r4_gap_before_aux: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(aux_o) |-> !$past(main_o));

  a_r9_fault_kills_main: assert property (@(posedge clk) disable iff (!rst_n)
    fault_i |=> !main_o);

  a_r5_snapshot_steady: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end_o |=> ($stable(per_q) && $stable(me_q) && $stable(ab_q)));

  a_r8_drain_no_main: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == FR_DRAIN) |=> !main_o);

endmodule

// File: rtl/clamp_pwm_seq.sv
module clamp_pwm_seq #(
  parameter int CNT_W   = 10,
  parameter int SS_DIV  = 16,
  parameter int SS_STEP = 1,
  parameter int MIN_ON  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] duty_i,
  input  logic [CNT_W-1:0] dly1_i,
  input  logic [CNT_W-1:0] dly2_i,
  input  logic             line_ok_i,
  input  logic             uv_flt_i,
  input  logic             oc_flt_i,
  input  logic             restart_i,
  output logic             main_o,
  output logic             aux_o,
  output logic             fault_o
);

  logic             srst_n;
  logic             frame_end;
  logic             flt;
  logic [CNT_W-1:0] limit;

  cpw_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  cpw_softstart #(
    .CNT_W   (CNT_W),
    .SS_DIV  (SS_DIV),
    .SS_STEP (SS_STEP)
  ) u_ss (
    .clk         (clk),
    .rst_n       (srst_n),
    .line_ok_i   (line_ok_i),
    .uv_flt_i    (uv_flt_i),
    .oc_flt_i    (oc_flt_i),
    .restart_i   (restart_i),
    .duty_i      (duty_i),
    .frame_end_i (frame_end),
    .fault_o     (flt),
    .limit_o     (limit)
  );

  cpw_frame #(
    .CNT_W  (CNT_W),
    .MIN_ON (MIN_ON)
  ) u_frame (
    .clk         (clk),
    .rst_n       (srst_n),
    .period_i    (period_i),
    .duty_i      (duty_i),
    .dly1_i      (dly1_i),
    .dly2_i      (dly2_i),
    .line_ok_i   (line_ok_i),
    .fault_i     (flt),
    .limit_i     (limit),
    .frame_end_o (frame_end),
    .main_o      (main_o),
    .aux_o       (aux_o)
  );

  assign fault_o = flt;

  a_r1_quiet_in_reset: assert property (@(posedge clk)
    !srst_n |-> (!main_o && !aux_o && !fault_o));

endmodule

// File: tb/clamp_pwm_seq_bench.sv
module clamp_pwm_seq_bench;

  localparam int CNT_W   = 8;
  localparam int SS_DIV  = 2;
  localparam int SS_STEP = 4;
  localparam int MIN_ON  = 3;
  localparam int MAXV    = (1 << CNT_W) - 1;

  logic             clk;
  logic             rst_n;
  logic [CNT_W-1:0] period_i, duty_i, dly1_i, dly2_i;
  logic             line_ok_i, uv_flt_i, oc_flt_i, restart_i;
  logic             main_o, aux_o, fault_o;

  clamp_pwm_seq #(
    .CNT_W(CNT_W), .SS_DIV(SS_DIV), .SS_STEP(SS_STEP), .MIN_ON(MIN_ON)
  ) u_clamp_pwm_seq (
    .clk(clk), .rst_n(rst_n), .period_i(period_i), .duty_i(duty_i),
    .dly1_i(dly1_i), .dly2_i(dly2_i), .line_ok_i(line_ok_i),
    .uv_flt_i(uv_flt_i), .oc_flt_i(oc_flt_i), .restart_i(restart_i),
    .main_o(main_o), .aux_o(aux_o), .fault_o(fault_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int    n_chk;
  int    n_bad;
  string tag;
  bit    done;

  // behavioural reference: slot model (mode 0 blank, 1 run, 2 drain)
  int m_rel, m_cnt, m_per, m_mb, m_me, m_ab, m_mode;
  int m_flt, m_lim, m_pc, m_main, m_aux;

  task automatic m_clear();
    m_cnt = 0; m_per = 0; m_mb = 0; m_me = 0; m_ab = 0; m_mode = 0;
    m_flt = 0; m_lim = 0; m_pc = 0; m_main = 0; m_aux = 0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rel = 0;
      m_clear();
    end else if (m_rel < 2) begin
      m_rel++;
      m_clear();
    end else begin
      int nm, na, last, d1, d2, room, on, nflt;
      nm = (m_mode == 1 && m_flt == 0 && m_cnt >= m_mb && m_cnt < m_me) ? 1 : 0;
      na = (m_mode != 0 && m_cnt >= m_ab && m_cnt < m_per) ? 1 : 0;
      last = (m_cnt + 1 >= m_per) ? 1 : 0;
      nflt = m_flt;
      if (uv_flt_i || oc_flt_i) nflt = 1;
      else if (m_flt == 1 && line_ok_i && restart_i) nflt = 0;
      if (last == 1) begin
        d1 = (dly1_i == 0) ? 1 : int'(dly1_i);
        d2 = (dly2_i == 0) ? 1 : int'(dly2_i);
        room = (d1 + d2 >= int'(period_i)) ? 0 : int'(period_i) - d1 - d2;
        on = int'(duty_i);
        if (m_lim < on) on = m_lim;
        if (room < on) on = room;
        m_cnt = 0;
        m_per = int'(period_i);
        m_mb = d1;
        if (!line_ok_i) begin
          m_mode = 2; m_me = d1; m_ab = d1 + d2;
        end else if (m_flt == 1 || on < MIN_ON) begin
          m_mode = 0; m_me = d1; m_ab = d1 + d2;
        end else begin
          m_mode = 1; m_me = d1 + on; m_ab = d1 + on + d2;
        end
      end else begin
        m_cnt++;
      end
      if (m_flt == 1 || !line_ok_i) begin
        m_lim = 0; m_pc = 0;
      end else if (last == 1) begin
        if (m_pc >= SS_DIV - 1) begin
          m_pc = 0;
          if (m_lim < int'(duty_i)) begin
            m_lim = m_lim + SS_STEP;
            if (m_lim > MAXV) m_lim = MAXV;
          end
        end else begin
          m_pc++;
        end
      end
      m_flt = nflt;
      m_main = nm;
      m_aux = na;
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      n_chk++;
      if (main_o !== 1'(m_main) || aux_o !== 1'(m_aux) || fault_o !== 1'(m_flt)) begin
        n_bad++;
        $display("FAIL %s t=%0t main/aux/fault actual %b%b%b expected %0d%0d%0d",
                 tag, $time, main_o, aux_o, fault_o, m_main, m_aux, m_flt);
      end
      if (main_o === 1'b1 && aux_o === 1'b1) begin
        n_bad++;
        $display("FAIL R2 overlap actual 11 expected not both");
      end
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_restart();
    @(negedge clk); restart_i = 1'b1;
    @(negedge clk); restart_i = 1'b0;
  endtask

  initial begin
    done = 1'b0;
    n_chk = 0; n_bad = 0;
    tag = "R1";
    rst_n = 1'b0;
    period_i = 8'd20; duty_i = 8'd8; dly1_i = 8'd2; dly2_i = 8'd3;
    line_ok_i = 1'b1; uv_flt_i = 1'b0; oc_flt_i = 1'b0; restart_i = 1'b0;
    cycles(6);
    rst_n = 1'b1;
    cycles(3);

    // R10 / R7: ramp climbs from zero, early periods blanked
    tag = "R10"; cycles(200);
    // R3: steady framing
    tag = "R3"; cycles(120);
    // R5: change settings mid-period
    tag = "R5"; cycles(7);
    duty_i = 8'd5; period_i = 8'd17;
    cycles(3); dly1_i = 8'd0; dly2_i = 8'd0;
    tag = "R4"; cycles(150);
    dly1_i = 8'd4; dly2_i = 8'd1; cycles(100);
    // R7: low command blanks both
    tag = "R7"; duty_i = 8'd2; cycles(120);
    // R6: command above the room
    tag = "R6"; duty_i = 8'd200; period_i = 8'd30; cycles(400);
    dly1_i = 8'd20; dly2_i = 8'd15; cycles(100);
    dly1_i = 8'd3; dly2_i = 8'd2;
    // R8: line loss drains the clamp
    tag = "R8"; line_ok_i = 1'b0; cycles(150);
    line_ok_i = 1'b1;
    tag = "R10"; duty_i = 8'd12; cycles(300);
    // R9: mid-period overcurrent, restart refused while asserted
    tag = "R9"; cycles(11);
    oc_flt_i = 1'b1; cycles(1); oc_flt_i = 1'b0; cycles(80);
    oc_flt_i = 1'b1; pulse_restart(); cycles(60);
    oc_flt_i = 1'b0; line_ok_i = 1'b0; pulse_restart(); cycles(40);
    line_ok_i = 1'b1; cycles(40);
    pulse_restart(); cycles(300);
    uv_flt_i = 1'b1; cycles(5); uv_flt_i = 1'b0; cycles(30);
    pulse_restart(); cycles(200);
    // R2: varied settings
    tag = "R2";
    for (int k = 0; k < 40; k++) begin
      period_i = 8'(10 + (k * 7) % 40);
      duty_i   = 8'((k * 13) % 35);
      dly1_i   = 8'(k % 4);
      dly2_i   = 8'((k * 3) % 5);
      line_ok_i = (k % 9 != 8);
      cycles(23 + k % 11);
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule